// File: doc/BRIEF.md
# Routable Interrupt Controller with Soft Interrupts

The controller gathers 32 interrupt sources and steers each of them, one by one, onto one of five interrupt lines toward a processor. Sources 0 to 15 are wired to hardware request inputs and latch on a rising edge. Sources 16 to 31 have no hardware input and act as software or inter-processor interrupts. Software raises them through a write-one-to-set port. The soft source for thread t is number 16+t.

Software sees four 64-bit register regions over a single-cycle bus. Writes take effect at the clock edge, and read data follows the address in the same cycle. Address bits [9:8] select the region: 0 holds the per-source configuration, 1 the pending word, 2 the set port and 3 the clear port. Inside the configuration region, source i sits at byte offset i*8. Each configuration word holds an enable, an output-line selector and a stored thread identifier. A line is raised while any source steered to it is both enabled and pending.

Top module: `irq_router`

## Requirements
- R1: After reset every configuration word reads zero, the pending word reads zero and all five output lines are low.
- R2: The configuration word of source i is at byte address i*8 with bits [9:8]=0. Bit 31 is the enable, bits [30:8] a thread identifier and bits [3:0] the line selector, and all other bits read back as zero.
- R3: Reading address 0x100 returns the pending bit of source i in bit i, with bits [63:32] zero. Reads in the set (0x200) and clear (0x300) regions return zero.
- R4: A write to 0x200 makes every source whose data bit [i] is 1 pending. Bits written as 0 and bits [63:32] leave the pending state unchanged.
- R5: A write to 0x300 clears the pending bit of every source whose data bit [i] is 1. Bits written as 0 and bits [63:32] leave the pending state unchanged.
- R6: A rising edge on hw_irq[i] (i < 16) sets pending bit i. The bit stays set until cleared, and a level held high does not set it again after a clear.
- R7: When a rising edge on hw_irq[i] and a clear of bit i fall in the same cycle, the bit ends up set.
- R8: Sources 16 to 31 become pending only through the set port. The soft source for thread t is number 16+t.
- R9: Output line k is high exactly while some source is pending, enabled and has selector k.
- R10: A source with selector 5 or more, or with the enable at 0, drives no line, and disabling a source leaves its pending bit in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for the current address |
| reg_addr | input | 10 | Byte address; bits [9:8] select the region |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, same cycle |
| hw_irq | input | 16 | Hardware request inputs of sources 0 to 15 |
| irq_out | output | 5 | Interrupt lines toward the processor |

## Verification
The bench goes after these corner cases:
- A clear that lands in the same cycle as a new hardware edge. A design that lets the clear win would lose that interrupt.
- A clear while the hardware input is still high. A level-triggered design would set the bit again at once and never let it be acknowledged.
- Selector values above the last line, and sources that are disabled while still pending. Here a design that drops the upper selector bits would raise a wrong line, and one that clears pending on disable would lose an interrupt.
- Garbage written into the reserved bits of configuration words and into the upper halves of the set and clear words. A design that fails here either reads those bits back or acts on them.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N_SRC   = 32,
  parameter int N_HW    = 16,
  parameter int N_LINES = 5,
  parameter int SEL_W   = 4,
  parameter int TID_W   = 23,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_HW-1:0]   hw_irq,
  output logic [N_LINES-1:0] irq_out
);
  localparam int IDX_W   = $clog2(N_SRC);
  localparam int WORD_LSB = 3;
  localparam int TID_LSB = 8;
  localparam int EN_BIT  = TID_LSB + TID_W;
  localparam logic [1:0] RG_CFG = 2'd0, RG_PEND = 2'd1, RG_SET = 2'd2, RG_CLR = 2'd3;

  logic [1:0]       region;
  logic [IDX_W-1:0] idx;
  logic             cfg_wr;
  logic [N_SRC-1:0] set_mask, clr_mask, hw_rise, pend_q, en_q;
  logic [N_SRC-1:0][SEL_W-1:0] sel_q;
  logic [N_SRC-1:0][TID_W-1:0] tid_q;
  logic [N_HW-1:0]  hw_prev;
  logic [N_LINES-1:0][N_SRC-1:0] hit;
  logic             unused_bits;

  assign region   = reg_addr[ADDR_W-1 -: 2];
  assign idx      = reg_addr[WORD_LSB +: IDX_W];
  assign cfg_wr   = reg_we && region == RG_CFG;
  assign set_mask = (reg_we && region == RG_SET) ? reg_wdata[N_SRC-1:0] : '0;
  assign clr_mask = (reg_we && region == RG_CLR) ? reg_wdata[N_SRC-1:0] : '0;
  assign hw_rise  = {{(N_SRC-N_HW){1'b0}}, hw_irq & ~hw_prev};
  assign unused_bits = ^{reg_addr, reg_wdata};

  for (genvar i = 0; i < N_SRC; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i]  <= 1'b0;
        sel_q[i] <= '0;
        tid_q[i] <= '0;
      end else if (cfg_wr && idx == IDX_W'(i)) begin
        en_q[i]  <= reg_wdata[EN_BIT];
        sel_q[i] <= reg_wdata[SEL_W-1:0];
        tid_q[i] <= reg_wdata[TID_LSB +: TID_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_prev <= '0;
      pend_q  <= '0;
    end else begin
      hw_prev <= hw_irq;
      pend_q  <= (pend_q & ~clr_mask) | set_mask | hw_rise;
    end
  end

  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign hit[k][i] = pend_q[i] & en_q[i] & (sel_q[i] == SEL_W'(k));
    end
    assign irq_out[k] = |hit[k];
  end

  always_comb begin
    reg_rdata = '0;
    case (region)
      RG_CFG: begin
        reg_rdata[SEL_W-1:0]         = sel_q[idx];
        reg_rdata[TID_LSB +: TID_W]  = tid_q[idx];
        reg_rdata[EN_BIT]            = en_q[idx];
      end
      RG_PEND: reg_rdata[N_SRC-1:0] = pend_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_SRC   = 32,
  parameter int N_HW    = 16,
  parameter int N_LINES = 5,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [N_HW-1:0]   hw_irq,
  input logic [N_LINES-1:0] irq_out,
  input logic [N_SRC-1:0]  pend_q
);
  logic is_set, is_clr, is_pend;
  assign is_set  = reg_we && reg_addr[ADDR_W-1 -: 2] == 2'd2;
  assign is_clr  = reg_we && reg_addr[ADDR_W-1 -: 2] == 2'd3;
  assign is_pend = reg_addr[ADDR_W-1 -: 2] == 2'd1;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> irq_out == '0); // R1
  AST_PEND_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) is_pend |-> reg_rdata[DATA_W-1:32] == '0); // R3
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n) is_set |=> (pend_q & $past(reg_wdata[N_SRC-1:0])) == $past(reg_wdata[N_SRC-1:0])); // R4
  AST_CLR_SOFT: assert property (@(posedge clk) disable iff (!rst_n) is_clr |=> (pend_q[N_SRC-1:N_HW] & $past(reg_wdata[N_SRC-1:N_HW])) == '0); // R5
  AST_SOFT_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n) !is_set |=> (pend_q[N_SRC-1:N_HW] & ~$past(pend_q[N_SRC-1:N_HW])) == '0); // R8
  AST_LINE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n) irq_out != '0 |-> pend_q != '0); // R9

  for (genvar i = 0; i < N_HW; i++) begin : g_edge
    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n) $rose(hw_irq[i]) |=> pend_q[i]); // R6 R7
  end
endmodule

bind irq_router irq_router_chk #(
  .N_SRC(N_SRC), .N_HW(N_HW), .N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_irq(hw_irq),
  .irq_out(irq_out), .pend_q(pend_q)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [15:0] hw_irq = '0;
  logic [4:0]  irq_out;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  irq_router dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_irq(hw_irq), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  localparam int TN = 19;
  // op 1 = write then check lines, op 0 = read and compare
  localparam logic        T_OP  [TN] = '{1,0,1,0,1,1,0,1,1,0,1,0,1,1,1,0,1,0,0};
  localparam logic [9:0]  T_ADR [TN] = '{10'h018,10'h018,10'h200,10'h100,10'h0A0,10'h200,10'h100,
                                         10'h0A8,10'h200,10'h100,10'h300,10'h100,10'h300,10'h0A8,
                                         10'h0A8,10'h100,10'h300,10'h100,10'h200};
  localparam logic [63:0] T_DAT [TN] = '{
    64'hFFFF_FFFF_8012_34F2, 64'h0000_0000_8012_3402,  // R2
    64'hFFFF_FFFF_0000_0008, 64'h0000_0000_0000_0008,  // R4 R3
    64'h0000_0000_8000_0004, 64'h0000_0000_0010_0000,  // R9
    64'h0000_0000_0010_0008,                          // R4
    64'h0000_0000_8000_0007, 64'h0000_0000_0020_0000,  // R10
    64'h0000_0000_0030_0008,
    64'hFFFF_FFFF_0000_0008, 64'h0000_0000_0030_0000,  // R5
    64'h0000_0000_0010_0000,
    64'h0000_0000_8000_0000, 64'h0000_0000_0000_0000,  // R9 R10
    64'h0000_0000_0020_0000,
    64'h0000_0000_0020_0000, 64'h0000_0000_0000_0000,  // R5
    64'h0000_0000_0000_0000};                         // R3
  localparam logic [4:0]  T_IRQ [TN] = '{5'h00,5'h00,5'h04,5'h04,5'h04,5'h14,5'h14,5'h14,5'h14,5'h14,
                                         5'h10,5'h10,5'h00,5'h01,5'h00,5'h00,5'h00,5'h00,5'h00};
  localparam int          T_REQ [TN] = '{2,2,4,3,9,9,4,10,10,4,5,5,5,9,10,10,5,5,3};

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [63:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata, exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(64'(irq_out), 64'h0, "R1");
    rd(10'h100, 64'h0, "R1");
    rd(10'h000, 64'h0, "R1");
    rd(10'h0F8, 64'h0, "R1");

    for (int n = 0; n < TN; n++) begin
      if (T_OP[n]) wr(T_ADR[n], T_DAT[n]);
      else rd(T_ADR[n], T_DAT[n], $sformatf("R%0d", T_REQ[n]));
      chk(64'(irq_out), 64'(T_IRQ[n]), $sformatf("R%0d", T_REQ[n]));
    end

    // R6 edge latch, level held through a clear does not re-latch
    wr(10'h028, 64'h8000_0001);
    hw_irq[5] = 1'b1;
    @(negedge clk);
    rd(10'h100, 64'h20, "R6");
    chk(64'(irq_out), 64'h02, "R6");
    wr(10'h300, 64'h20);
    @(negedge clk);
    rd(10'h100, 64'h0, "R6");
    chk(64'(irq_out), 64'h0, "R6");
    hw_irq[5] = 1'b0;
    @(negedge clk);
    hw_irq[5] = 1'b1;
    @(negedge clk);
    rd(10'h100, 64'h20, "R6");
    hw_irq[5] = 1'b0;
    wr(10'h300, 64'h20);

    // R7 edge and clear in the same cycle
    wr(10'h200, 64'h40);
    @(negedge clk);
    hw_irq[6] = 1'b1;
    reg_we = 1'b1; reg_addr = 10'h300; reg_wdata = 64'h40;
    @(negedge clk);
    reg_we = 1'b0;
    rd(10'h100, 64'h40, "R7");
    hw_irq[6] = 1'b0;
    wr(10'h300, 64'h40);
    rd(10'h100, 64'h0, "R7");

    // R8 hardware toggling never reaches soft sources; IPI for thread 2
    hw_irq = 16'hFFFF;
    @(negedge clk);
    hw_irq = 16'h0000;
    @(negedge clk);
    rd(10'h100, 64'h0000_FFFF, "R8");
    wr(10'h300, 64'hFFFF);
    wr(10'h090, 64'h8000_0203);
    rd(10'h090, 64'h8000_0203, "R8");
    wr(10'h200, 64'h0004_0000);
    rd(10'h100, 64'h0004_0000, "R8");
    chk(64'(irq_out), 64'h08, "R8");

    // R2 all-ones config word, R10 selector 15 drives nothing
    wr(10'h0F8, '1);
    rd(10'h0F8, 64'h0000_0000_FFFF_FF0F, "R2");
    wr(10'h200, 64'h8000_0000);
    chk(64'(irq_out), 64'h08, "R10");
    wr(10'h300, 64'h8004_0000);
    chk(64'(irq_out), 64'h00, "R5");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule